// File: doc/BRIEF.md
# Multi-mode 24-bit timer counter

This block is a timer built around a single 24-bit up-counter that wraps modulo 2^24. A small word-wide register port sets it up, and its two-bit mode field picks what the counter does. It can run as an interval timer with a compare value, as a pulse generator that toggles an output flop at two compare points, or as a watchdog that expires at a compare value. In the fourth mode it is switched off. The counter steps on a count tick. The tick comes either from the block clock, optionally divided by a power of two, or from rising edges of an external clock input that is synchronized into the block clock domain.

Every compare event sets a bit in a sticky status register. If the event's enable bit is set, the event also raises a level interrupt. Software clears all status bits and the interrupt together by writing the status register. The pulse output flop is preset from a mode-register bit while the timer is stopped.

Top module: `tmr24`

## Requirements
- R1: After reset, the following read back as zero: control (0x00), status (0x04), interval mode (0x10), divider (0x20), pulse mode (0x30), watchdog mode (0x40) and counter (0xF0). Both compare registers (0x08, 0x0C) read 0xFFFFFF. `irq` and `pulse_out` are 0.
- R2: Writes to the control register take effect only through byte lane 0. Bit 4 is always stored as 0. Writes to the compare registers take effect only through byte lanes 0 to 2, so bits 31:24 read 0. Control fields are: run bit 7, divider enable bit 6, clear-on-stop bit 5, external clock select bit 2, mode bits 1:0 (0 interval, 1 pulse, 2 watchdog, 3 off).
- R3: In mode 3 the counter never changes, whatever the run bit says. In interval and pulse modes the counter advances only while the run bit is 1.
- R4: A control write that leaves run at 0 and clear-on-stop at 1 sets the counter to 0. A control write with both bits at 0 leaves the counter value unchanged.
- R5: With the internal clock and the divider disabled, the counter advances once per clock. With the divider enabled, it advances once every 2^(N+1) clocks, where N is divider register bits 2:0; the prescaler restarts whenever the clock select, divider enable or N changes. With the external clock selected, the counter advances once per rising edge of `ext_clk`.
- R6: In interval mode with zero-clear (interval mode bit 0) set, the tick whose next count equals compare A puts the counter at 0 and sets status bit 0. The counter therefore repeats with period equal to compare A.
- R7: In interval mode with zero-clear at 0, the counter stops at compare A and status bit 0 is set. The interrupt is raised at arrival if interval mode bit 15 is set.
- R8: In pulse mode, the tick that reaches compare A toggles `pulse_out` and sets status bit 1. The tick that reaches compare B toggles `pulse_out`, sets status bit 2 and clears the counter. When both compares are equal, compare A takes priority. The interrupt enables are pulse mode bit 14 for compare A and bit 15 for compare B.
- R9: In watchdog mode, the tick that reaches compare A sets status bit 3 and clears the counter. Watchdog mode bit 15 enables the interrupt. The watchdog stops only when run is 0 and the disable bit (watchdog mode bit 7) is 1.
- R10: `irq` goes high only for a compare event whose enable bit is set. A compare event whose enable bit is clear sets its status bit and leaves `irq` low.
- R11: A write to byte lane 0 of the status register clears all status bits and `irq`. If a compare event happens in the same cycle as that write, the event's status bit and interrupt survive.
- R12: A write to byte lane 0 of the pulse mode register while run is 0 loads `pulse_out` with bit 0 of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_be | input | 4 | Byte lane enables, bit 0 = data bits 7:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |
| pulse_out | output | 1 | Pulse generator flip-flop |

## Verification
A software status clear and a compare event can land in the same clock edge, and they act on the same status bits and interrupt flop. The bench runs the pulse generator from a cleared counter and counts ticks from the control write. It issues the status write so that it is captured on exactly the edge where the counter reaches compare A. The check then requires the compare A status bit and `irq` to read 1 after that edge, not 0. A second status write on a quiet cycle must clear both.

// File: rtl/tmr24_pkg.sv
package tmr24_pkg;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'd0,
        MODE_PULSE    = 2'd1,
        MODE_WDOG     = 2'd2,
        MODE_OFF      = 2'd3
    } tmode_e;

    // Control byte; bit positions match the register layout.
    typedef struct packed {
        logic   run;
        logic   div_en;
        logic   clr_en;
        logic   rsv4;
        logic   rsv3;
        logic   ext_sel;
        tmode_e mode;
    } ctrl_t;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_CMPA  = 8'h08;
    localparam logic [7:0] OFS_CMPB  = 8'h0C;
    localparam logic [7:0] OFS_IMODE = 8'h10;
    localparam logic [7:0] OFS_DIV   = 8'h20;
    localparam logic [7:0] OFS_PMODE = 8'h30;
    localparam logic [7:0] OFS_WMODE = 8'h40;
    localparam logic [7:0] OFS_COUNT = 8'hF0;

    localparam logic [7:0] CTRL_WMASK = 8'hEF;

endpackage

// File: rtl/tmr24_regs.sv
module tmr24_regs
    import tmr24_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       addr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [3:0]       status,
    output logic [31:0]      rdata,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b,
    output logic [DIV_W-1:0] div_sel,
    output logic             iv_ie,
    output logic             iv_zc,
    output logic             pa_ie,
    output logic             pb_ie,
    output logic             wd_ie,
    output logic             wd_dis,
    output logic             st_wr,
    output logic             ctrl_clr,
    output logic             ff_load,
    output logic             ff_val
);
    localparam int CMP_BYTES = CNT_W / 8;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cmp_a;
        logic [CNT_W-1:0] cmp_b;
        logic [DIV_W-1:0] div_sel;
        logic             iv_ie;
        logic             iv_zc;
        logic             pa_ie;
        logic             pb_ie;
        logic             ffi;
        logic             wd_ie;
        logic             wd_dis;
        logic             wd_kick;
    } regs_t;

    regs_t q, d;
    logic  unused_hi;

    assign unused_hi = ^wdata[31:24];

    always_comb begin
        d        = q;
        st_wr    = 1'b0;
        ctrl_clr = 1'b0;
        ff_load  = 1'b0;
        ff_val   = wdata[0];
        if (wr) begin
            case (addr)
                OFS_CTRL: if (be[0]) begin
                    d.ctrl   = ctrl_t'(wdata[7:0] & CTRL_WMASK);
                    ctrl_clr = !wdata[7] && wdata[5];
                end
                OFS_STAT: st_wr = be[0];
                OFS_CMPA: for (int b = 0; b < CMP_BYTES; b++)
                    if (be[b]) d.cmp_a[8*b +: 8] = wdata[8*b +: 8];
                OFS_CMPB: for (int b = 0; b < CMP_BYTES; b++)
                    if (be[b]) d.cmp_b[8*b +: 8] = wdata[8*b +: 8];
                OFS_IMODE: begin
                    if (be[1]) d.iv_ie = wdata[15];
                    if (be[0]) d.iv_zc = wdata[0];
                end
                OFS_DIV: if (be[0]) d.div_sel = wdata[DIV_W-1:0];
                OFS_PMODE: begin
                    if (be[1]) begin
                        d.pb_ie = wdata[15];
                        d.pa_ie = wdata[14];
                    end
                    if (be[0]) begin
                        d.ffi   = wdata[0];
                        ff_load = !q.ctrl.run;
                    end
                end
                OFS_WMODE: begin
                    if (be[1]) d.wd_ie = wdata[15];
                    if (be[0]) begin
                        d.wd_dis  = wdata[7];
                        d.wd_kick = wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.cmp_a <= '1;
            q.cmp_b <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL:  rdata = 32'(q.ctrl);
            OFS_STAT:  rdata = 32'(status);
            OFS_CMPA:  rdata = 32'(q.cmp_a);
            OFS_CMPB:  rdata = 32'(q.cmp_b);
            OFS_IMODE: begin rdata[15] = q.iv_ie; rdata[0] = q.iv_zc; end
            OFS_DIV:   rdata = 32'(q.div_sel);
            OFS_PMODE: begin rdata[15] = q.pb_ie; rdata[14] = q.pa_ie; rdata[0] = q.ffi; end
            OFS_WMODE: begin rdata[15] = q.wd_ie; rdata[7] = q.wd_dis; rdata[0] = q.wd_kick; end
            OFS_COUNT: rdata = 32'(cnt);
            default:   rdata = '0;
        endcase
    end

    assign ctrl    = q.ctrl;
    assign cmp_a   = q.cmp_a;
    assign cmp_b   = q.cmp_b;
    assign div_sel = q.div_sel;
    assign iv_ie   = q.iv_ie;
    assign iv_zc   = q.iv_zc;
    assign pa_ie   = q.pa_ie;
    assign pb_ie   = q.pb_ie;
    assign wd_ie   = q.wd_ie;
    assign wd_dis  = q.wd_dis;

endmodule

// File: rtl/tmr24_tick.sv
module tmr24_tick #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    input  logic             ext_sel,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PS_W  = 1 << DIV_W;
    localparam int CFG_W = DIV_W + 2;

    typedef struct packed {
        logic [PS_W-1:0]  presc;
        logic [2:0]       sync;
        logic [CFG_W-1:0] cfg;
    } tick_t;

    tick_t            q, d;
    logic [PS_W-1:0]  limit;
    logic [CFG_W-1:0] cfg_now;
    logic             changed;
    logic             ext_edge;

    always_comb begin
        cfg_now  = {ext_sel, div_en, div_sel};
        changed  = (cfg_now != q.cfg);
        limit    = {PS_W{1'b1}} >> (PS_W - 1 - int'(div_sel));
        ext_edge = q.sync[1] && !q.sync[2];

        d      = q;
        d.cfg  = cfg_now;
        d.sync = {q.sync[1:0], ext_clk};
        if (changed || q.presc == limit) d.presc = '0;
        else                             d.presc = q.presc + 1'b1;

        if (ext_sel)     tick = ext_edge;
        else if (!div_en) tick = 1'b1;
        else             tick = (q.presc == limit) && !changed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/tmr24_core.sv
module tmr24_core
    import tmr24_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmode_e           mode,
    input  logic             run,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             iv_ie,
    input  logic             iv_zc,
    input  logic             pa_ie,
    input  logic             pb_ie,
    input  logic             wd_ie,
    input  logic             wd_dis,
    input  logic             st_wr,
    input  logic             ctrl_clr,
    input  logic             ff_load,
    input  logic             ff_val,
    output logic [CNT_W-1:0] cnt,
    output logic [3:0]       status,
    output logic             irq,
    output logic             ff
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [3:0]       status;
        logic             irq;
        logic             ff;
    } core_t;

    core_t            q, d;
    logic [CNT_W-1:0] nxt;
    logic [3:0]       set;
    logic             fire;
    logic             adv;

    always_comb begin
        d    = q;
        nxt  = q.cnt + 1'b1;
        set  = '0;
        fire = 1'b0;
        case (mode)
            MODE_INTERVAL: adv = run && (q.cnt != cmp_a);
            MODE_PULSE:    adv = run;
            MODE_WDOG:     adv = run || !wd_dis;
            default:       adv = 1'b0;
        endcase

        if (tick && adv) begin
            d.cnt = nxt;
            case (mode)
                MODE_INTERVAL: if (nxt == cmp_a) begin
                    set[0] = 1'b1;
                    fire   = iv_ie;
                    d.cnt  = iv_zc ? '0 : cmp_a;
                end
                MODE_PULSE: if (nxt == cmp_a) begin
                    d.ff   = !q.ff;
                    set[1] = 1'b1;
                    fire   = pa_ie;
                end else if (nxt == cmp_b) begin
                    d.ff   = !q.ff;
                    set[2] = 1'b1;
                    fire   = pb_ie;
                    d.cnt  = '0;
                end
                MODE_WDOG: if (nxt == cmp_a) begin
                    set[3] = 1'b1;
                    fire   = wd_ie;
                    d.cnt  = '0;
                end
                default: ;
            endcase
        end

        if (ctrl_clr) d.cnt = '0;
        if (ff_load)  d.ff  = ff_val;
        d.status = (st_wr ? 4'd0 : q.status) | set;
        d.irq    = (st_wr ? 1'b0 : q.irq) | fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt    = q.cnt;
    assign status = q.status;
    assign irq    = q.irq;
    assign ff     = q.ff;

endmodule

// File: rtl/tmr24.sv
module tmr24
    import tmr24_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int DIV_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_clk,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        pulse_out
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cmp_a, cmp_b, cnt_w;
    logic [DIV_W-1:0] div_sel;
    logic             iv_ie, iv_zc, pa_ie, pb_ie, wd_ie, wd_dis_w;
    logic             st_wr_w, ctrl_clr_w, ff_load_w, ff_val;
    logic [3:0]       status_w;
    logic             tick;
    logic [1:0]       mode_w;
    logic             run_w;
    logic             unused_rsv;

    assign mode_w     = ctrl.mode;
    assign run_w      = ctrl.run;
    assign unused_rsv = ctrl.clr_en ^ ctrl.rsv4 ^ ctrl.rsv3;

    tmr24_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
        .wdata(bus_wdata), .cnt(cnt_w), .status(status_w), .rdata(bus_rdata),
        .ctrl(ctrl), .cmp_a(cmp_a), .cmp_b(cmp_b), .div_sel(div_sel),
        .iv_ie(iv_ie), .iv_zc(iv_zc), .pa_ie(pa_ie), .pb_ie(pb_ie),
        .wd_ie(wd_ie), .wd_dis(wd_dis_w), .st_wr(st_wr_w),
        .ctrl_clr(ctrl_clr_w), .ff_load(ff_load_w), .ff_val(ff_val)
    );

    tmr24_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_sel(ctrl.ext_sel),
        .div_en(ctrl.div_en), .div_sel(div_sel), .tick(tick)
    );

    tmr24_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctrl.mode), .run(run_w),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .iv_ie(iv_ie), .iv_zc(iv_zc),
        .pa_ie(pa_ie), .pb_ie(pb_ie), .wd_ie(wd_ie), .wd_dis(wd_dis_w),
        .st_wr(st_wr_w), .ctrl_clr(ctrl_clr_w), .ff_load(ff_load_w),
        .ff_val(ff_val), .cnt(cnt_w), .status(status_w), .irq(irq),
        .ff(pulse_out)
    );

endmodule

// File: rtl/tmr24_checks.sv
module tmr24_checks #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             run,
    input logic             wd_dis,
    input logic [CNT_W-1:0] cnt,
    input logic [3:0]       status,
    input logic             irq,
    input logic             ff,
    input logic             st_wr,
    input logic             ctrl_clr,
    input logic             ff_load
);
    assert_off_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (cnt == $past(cnt) || cnt == '0));

    assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> (cnt == '0));

    assert_ff_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd1 && !ff_load) |=> $stable(ff));

    assert_wdog_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !run && wd_dis) |=> (cnt == $past(cnt) || cnt == '0));

    assert_irq_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 4'd0));

    assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((status & $past(status)) == $past(status)));

endmodule

bind tmr24 tmr24_checks #(.CNT_W(CNT_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .run(run_w), .wd_dis(wd_dis_w),
    .cnt(cnt_w), .status(status_w), .irq(irq), .ff(pulse_out),
    .st_wr(st_wr_w), .ctrl_clr(ctrl_clr_w), .ff_load(ff_load_w)
);

// File: tb/tmr24_bench.sv
`timescale 1ns/1ps
module tmr24_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, pulse_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmr24 u_tmr24 (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .pulse_out(pulse_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write is captured on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] v, input logic [3:0] b = 4'hF);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v; bus_be = b;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Stop the counter, zero it and clear status.
    task automatic clear_all();
        wr(8'h00, 32'h20);
        wr(8'h04, 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rchk("R1 ctrl", 8'h00, 32'h0);
        rchk("R1 status", 8'h04, 32'h0);
        rchk("R1 cmpa", 8'h08, 32'h00FFFFFF);
        rchk("R1 cmpb", 8'h0C, 32'h00FFFFFF);
        rchk("R1 imode", 8'h10, 32'h0);
        rchk("R1 div", 8'h20, 32'h0);
        rchk("R1 pmode", 8'h30, 32'h0);
        rchk("R1 wmode", 8'h40, 32'h0);
        rchk("R1 count", 8'hF0, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pulse_out", {31'b0, pulse_out}, 32'h0);

        // R2 write masks
        wr(8'h00, 32'h0000FFFF);
        rchk("R2 ctrl bit4 masked", 8'h00, 32'h000000EF);
        wr(8'h00, 32'h000000FF, 4'b0010);
        rchk("R2 ctrl upper lane ignored", 8'h00, 32'h000000EF);
        wr(8'h00, 32'h00000013);
        rchk("R2 ctrl masked again", 8'h00, 32'h00000003);
        wr(8'h08, 32'hAB123456);
        rchk("R2 cmpa top byte", 8'h08, 32'h00123456);
        wr(8'h0C, 32'hCD00BEEF, 4'b1001);
        rchk("R2 cmpb lanes", 8'h0C, 32'h00FFFFEF);
        rchk("R2 other offset", 8'h14, 32'h0);

        // R3 mode 3 never counts; interval needs run
        wr(8'h00, 32'h83);
        idle(10);
        rchk("R3 off mode frozen", 8'hF0, 32'h0);
        wr(8'h00, 32'h00);
        idle(10);
        rchk("R3 interval no run", 8'hF0, 32'h0);

        // R6 interval wrap, several compare values, irq disabled (R10)
        for (int c = 2; c <= 6; c++) begin
            clear_all();
            wr(8'h08, c);
            wr(8'h10, 32'h0001);
            wr(8'h00, 32'h80);
            for (int m = 1; m <= 3 * c; m++) begin
                @(negedge clk);
                rchk("R6 interval count", 8'hF0, m % c);
                rchk("R6 status bit0", 8'h04, (m >= c) ? 32'h1 : 32'h0);
                chk("R10 irq disabled", {31'b0, irq}, 32'h0);
            end
        end

        // R7 hold at compare A with interrupt
        clear_all();
        wr(8'h08, 4);
        wr(8'h10, 32'h8000);
        wr(8'h00, 32'h80);
        for (int m = 1; m <= 9; m++) begin
            @(negedge clk);
            rchk("R7 hold count", 8'hF0, (m < 4) ? m : 4);
            chk("R7 irq at arrival", {31'b0, irq}, (m >= 4) ? 32'h1 : 32'h0);
        end

        // R4 stop without clear keeps, with clear zeroes
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h00);
        idle(3);
        rchk("R4 stop keeps count", 8'hF0, 32'h4);
        wr(8'h00, 32'h20);
        rchk("R4 stop clears count", 8'hF0, 32'h0);

        // R5 divided internal clock
        for (int n = 0; n <= 3; n++) begin
            int p;
            p = 2 << n;
            clear_all();
            wr(8'h08, 32'h00FFFFFF);
            wr(8'h10, 32'h0);
            wr(8'h20, n);
            wr(8'h00, 32'hC0);
            for (int m = 1; m <= 3 * p + 2; m++) begin
                @(negedge clk);
                rchk("R5 divided count", 8'hF0, (m - 1) / p);
            end
        end

        // R5 external clock edges
        clear_all();
        wr(8'h00, 32'h84);
        idle(5);
        rchk("R5 ext idle", 8'hF0, 32'h0);
        for (int k = 0; k < 7; k++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        idle(4);
        rchk("R5 ext edges", 8'hF0, 32'h7);

        // R8 pulse mode, compare A interrupt enabled
        clear_all();
        wr(8'h08, 3);
        wr(8'h0C, 7);
        wr(8'h30, 32'h4000);
        wr(8'h00, 32'h81);
        for (int m = 1; m <= 14; m++) begin
            @(negedge clk);
            rchk("R8 pulse count", 8'hF0, m % 7);
            chk("R8 pulse_out", {31'b0, pulse_out}, ((m % 7) >= 3) ? 32'h1 : 32'h0);
            rchk("R8 status", 8'h04, ((m >= 3) ? 32'h2 : 32'h0) | ((m >= 7) ? 32'h4 : 32'h0));
            chk("R10 irq compare A", {31'b0, irq}, (m >= 3) ? 32'h1 : 32'h0);
        end

        // R12 preset, then pulse mode with no interrupt enables (R10)
        clear_all();
        wr(8'h30, 32'h0001);
        chk("R12 preset loads 1", {31'b0, pulse_out}, 32'h1);
        wr(8'h00, 32'h81);
        for (int m = 1; m <= 10; m++) begin
            @(negedge clk);
            chk("R12 inverted pulse", {31'b0, pulse_out}, ((m % 7) >= 3) ? 32'h0 : 32'h1);
            chk("R10 irq stays low", {31'b0, irq}, 32'h0);
        end
        clear_all();
        wr(8'h30, 32'h0000);
        chk("R12 preset loads 0", {31'b0, pulse_out}, 32'h0);

        // R8 equal compares: A wins, no clear
        wr(8'h08, 4);
        wr(8'h0C, 4);
        wr(8'h00, 32'h81);
        idle(6);
        rchk("R8 priority count", 8'hF0, 32'h6);
        rchk("R8 priority status", 8'h04, 32'h2);

        // R9 watchdog
        clear_all();
        wr(8'h08, 5);
        wr(8'h40, 32'h8000);
        wr(8'h00, 32'h82);
        for (int m = 1; m <= 12; m++) begin
            @(negedge clk);
            rchk("R9 wdog count", 8'hF0, m % 5);
            rchk("R9 status bit3", 8'h04, (m >= 5) ? 32'h8 : 32'h0);
            chk("R9 irq", {31'b0, irq}, (m >= 5) ? 32'h1 : 32'h0);
        end
        wr(8'h00, 32'h02);
        rd(8'hF0, v);
        idle(2);
        rd(8'hF0, v2);
        chk("R9 runs with run=0 and no disable", {31'b0, v != v2}, 32'h1);
        wr(8'h40, 32'h8080);
        rd(8'hF0, v);
        idle(5);
        rchk("R9 halted by disable", 8'hF0, v);

        // R11 status clear colliding with a compare event
        clear_all();
        wr(8'h08, 3);
        wr(8'h0C, 32'h00FFFFFF);
        wr(8'h30, 32'h4000);
        wr(8'h00, 32'h81);
        idle(2);
        wr(8'h04, 32'h0);
        rchk("R11 collision count", 8'hF0, 32'h3);
        rchk("R11 event survives clear", 8'h04, 32'h2);
        chk("R11 irq survives clear", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h0);
        rchk("R11 plain clear status", 8'h04, 32'h0);
        chk("R11 plain clear irq", {31'b0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule